// File: doc/BRIEF.md
# Reset Source Capture Register

This block merges every reset request in the system into one synchronous system reset pulse and records which request caused it. The sources are: the power-on detector, a supply-monitor trip, an external reset pin, a watchdog expiry, a missing-clock event, a comparator level and a flash access error. Software can also force a reset through the register. A fixed-length pulse is driven on `sys_rst_o`, and the cause is stored as a one-hot flag byte.

Software reaches the block through one 8-bit register. Four of its bits have two roles. A write to them sets a source enable, or for bit 4 a force command. A plain read returns the cause flags. A read-modify-write read cycle instead returns the stored enables in those four positions, so that a modify-and-write-back never turns a cause flag into an enable or into a forced reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A plain read (`rd_en_i` high, `rmw_en_i` low) returns the cause flags in this layout: bit 6 flash error, bit 5 comparator, bit 4 software, bit 3 watchdog, bit 2 missing clock, bit 1 power-on/supply monitor, bit 0 pin. Bit 7 always reads 0.
- R2: A read with `rmw_en_i` high returns the comparator enable in bit 5, 0 in bit 4, the missing-clock enable in bit 2 and the supply-monitor enable in bit 1. Bits 7, 6, 3 and 0 read as in R1.
- R3: A write stores bits 5, 2 and 1 as the comparator, missing-clock and supply-monitor enables. Written values in bits 7, 6, 3 and 0 change nothing that can be read.
- R4: Writing 1 to bit 4 forces a reset with cause flags 0x10. Writing 0 to bit 4 causes no reset.
- R5: With the comparator enabled, a low `cmp_n_i` causes a reset with flags 0x20. With it disabled, the level is ignored.
- R6: With the missing-clock enable set, `clk_miss_i` causes a reset with flags 0x04. With it clear, the event is ignored.
- R7: While `por_n` is low, `sys_rst_o` is high, the flags read 0x02, and the enables are comparator 0, missing clock 0, supply monitor 1, so the read-modify-write view reads 0x02. After release, `sys_rst_o` falls at the 16th rising clock edge.
- R8: With the supply-monitor enable set, `vmon_trip_i` causes a reset with flags 0x02 and leaves the enables unchanged. With the enable clear, the trip is ignored.
- R9: The pin, watchdog and flash-error inputs always cause a reset, with flags 0x01, 0x08 and 0x40 respectively. Exactly one flag is set at any time.
- R10: Simultaneous requests resolve by fixed priority: supply monitor, pin, watchdog, missing clock, comparator, flash error, software.
- R11: A request sampled at a rising edge sets `sys_rst_o` at that edge and latches the flags there. `sys_rst_o` falls at the 16th following rising edge (parameter `HOLD`).
- R12: While `sys_rst_o` is high, requests and register writes are ignored. Flags, enables and pulse length are unaffected, and a reset other than power-on keeps the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| vmon_trip_i | input | 1 | Supply-monitor trip event |
| pin_rst_i | input | 1 | External reset pin request |
| wdt_expire_i | input | 1 | Watchdog expiry event |
| clk_miss_i | input | 1 | Missing-clock event |
| cmp_n_i | input | 1 | Comparator output, low requests reset |
| flash_err_i | input | 1 | Flash access error event |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Plain read strobe |
| rmw_en_i | input | 1 | Read-modify-write read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no read strobe |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The hardest case is a second request, plus a write that would clear every enable, landing while a pulse is already running. The bench starts a pin reset and, on the first edge inside the pulse, raises the watchdog together with a force-and-clear write. It then confirms that the pulse still ends at exactly 16 edges, that the flags still read the pin cause, and that the read-modify-write view still shows the old enables. The priority cases drive several sources in one cycle, including a forced software write alongside a flash error.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int FLAG_W  = 7;
  localparam int B_PIN   = 0;
  localparam int B_POR   = 1;
  localparam int B_MCD   = 2;
  localparam int B_WDT   = 3;
  localparam int B_SW    = 4;
  localparam int B_CMP   = 5;
  localparam int B_FLASH = 6;

  typedef struct packed {
    logic vmon;
    logic pin;
    logic wdt;
    logic mcd;
    logic cmp;
    logic flash;
    logic sw;
  } req_t;

  typedef struct packed {
    logic cmp;
    logic mcd;
    logic vmon;
  } en_t;

  // Highest-priority request wins; result is a one-hot flag vector.
  function automatic logic [FLAG_W-1:0] pick_cause(req_t r);
    logic [FLAG_W-1:0] c;
    c = '0;
    if (r.vmon)       c[B_POR]   = 1'b1;
    else if (r.pin)   c[B_PIN]   = 1'b1;
    else if (r.wdt)   c[B_WDT]   = 1'b1;
    else if (r.mcd)   c[B_MCD]   = 1'b1;
    else if (r.cmp)   c[B_CMP]   = 1'b1;
    else if (r.flash) c[B_FLASH] = 1'b1;
    else if (r.sw)    c[B_SW]    = 1'b1;
    return c;
  endfunction

  function automatic logic [7:0] flag_view(logic [FLAG_W-1:0] f);
    return {1'b0, f};
  endfunction

  // Dual-role bits show the stored enables; the force bit reads 0.
  function automatic logic [7:0] enable_view(logic [FLAG_W-1:0] f, en_t e);
    logic [7:0] v;
    v        = {1'b0, f};
    v[B_CMP] = e.cmp;
    v[B_SW]  = 1'b0;
    v[B_MCD] = e.mcd;
    v[B_POR] = e.vmon;
    return v;
  endfunction
endpackage

// File: rtl/rst_req_arbiter.sv
module rst_req_arbiter
  import rst_cause_pkg::*;
(
  input  logic              busy,
  input  en_t               en,
  input  logic              vmon_trip,
  input  logic              pin_rst,
  input  logic              wdt_expire,
  input  logic              clk_miss,
  input  logic              cmp_n,
  input  logic              flash_err,
  input  logic              sw_force,
  output logic              trigger,
  output logic [FLAG_W-1:0] cause
);
  req_t req;

  always_comb begin
    req.vmon  = vmon_trip & en.vmon;
    req.pin   = pin_rst;
    req.wdt   = wdt_expire;
    req.mcd   = clk_miss & en.mcd;
    req.cmp   = ~cmp_n & en.cmp;
    req.flash = flash_err;
    req.sw    = sw_force;
    if (busy) req = '0;
  end

  assign cause   = pick_cause(req);
  assign trigger = |req;

  always_comb begin
    if (trigger) AST_CAUSE_ONEHOT: assert ($onehot(cause)); // R10
  end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           cnt <= CW'(HOLD);
    else if (load)        cnt <= CW'(HOLD);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!por_n)
    load |=> (cnt == CW'(HOLD))); // R11
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!por_n)
    (active && !load) |=> (cnt == CW'($past(cnt) - 1'b1))); // R11
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int HOLD = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       vmon_trip_i,
  input  logic       pin_rst_i,
  input  logic       wdt_expire_i,
  input  logic       clk_miss_i,
  input  logic       cmp_n_i,
  input  logic       flash_err_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic       rmw_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sys_rst_o
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] cause;
  en_t               en;
  logic              trigger;
  logic              wr_take;
  logic              sw_force;
  logic              unused_wbits;

  assign wr_take      = wr_en_i & ~sys_rst_o;
  assign sw_force     = wr_en_i & wdata_i[B_SW];
  assign unused_wbits = ^{wdata_i[7], wdata_i[B_FLASH], wdata_i[B_WDT], wdata_i[B_PIN]};

  rst_req_arbiter u_arb (
    .busy       (sys_rst_o),
    .en         (en),
    .vmon_trip  (vmon_trip_i),
    .pin_rst    (pin_rst_i),
    .wdt_expire (wdt_expire_i),
    .clk_miss   (clk_miss_i),
    .cmp_n      (cmp_n_i),
    .flash_err  (flash_err_i),
    .sw_force   (sw_force),
    .trigger    (trigger),
    .cause      (cause)
  );

  rst_pulse_gen #(.HOLD(HOLD)) u_pulse (
    .clk    (clk),
    .por_n  (por_n),
    .load   (trigger),
    .active (sys_rst_o)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags          <= '0;
      flags[B_POR]   <= 1'b1;
      en.cmp         <= 1'b0;
      en.mcd         <= 1'b0;
      en.vmon        <= 1'b1;
    end else begin
      if (trigger) flags <= cause;
      if (wr_take) begin
        en.cmp  <= wdata_i[B_CMP];
        en.mcd  <= wdata_i[B_MCD];
        en.vmon <= wdata_i[B_POR];
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rmw_en_i)     rdata_o = enable_view(flags, en);
    else if (rd_en_i) rdata_o = flag_view(flags);
  end

  always_comb begin
    AST_BIT7_ZERO: assert (rdata_o[7] == 1'b0); // R1
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    $countones(flags) == 1); // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !trigger |=> $stable(flags)); // R9
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!por_n)
    trigger |=> sys_rst_o); // R11
  AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_o |=> $stable(en)); // R12
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       vmon_trip = 1'b0, pin_rst = 1'b0, wdt_expire = 1'b0;
  logic       clk_miss = 1'b0, cmp_n = 1'b1, flash_err = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rmw_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sys_rst;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_cause_ctrl #(.HOLD(16)) uut (
    .clk(clk), .por_n(por_n), .vmon_trip_i(vmon_trip), .pin_rst_i(pin_rst),
    .wdt_expire_i(wdt_expire), .clk_miss_i(clk_miss), .cmp_n_i(cmp_n),
    .flash_err_i(flash_err), .wr_en_i(wr_en), .rd_en_i(rd_en), .rmw_en_i(rmw_en),
    .wdata_i(wdata), .rdata_o(rdata), .sys_rst_o(sys_rst)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic rd_plain(output logic [7:0] v);
    rd_en = 1'b1; #1; v = rdata; rd_en = 1'b0;
  endtask

  task automatic rd_rmw(output logic [7:0] v);
    rmw_en = 1'b1; #1; v = rdata; rmw_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
  endtask

  // Counts rising edges from now until sys_rst is seen low.
  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst && n < 40) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic expect_reset(input string tag, input logic [7:0] flags_exp);
    logic [7:0] v;
    int n;
    check({tag, " reset asserted"}, sys_rst, 1);
    rd_plain(v);
    check({tag, " flags"}, v, flags_exp);
    pulse_len(n);
    check({tag, " R11 pulse length"}, n, 16);
  endtask

  task automatic expect_quiet(input string tag, input logic [7:0] flags_exp);
    logic [7:0] v;
    repeat (2) @(negedge clk);
    check({tag, " no reset"}, sys_rst, 0);
    rd_plain(v);
    check({tag, " flags kept"}, v, flags_exp);
  endtask

  task automatic t_por;
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    check("R7 reset held in por", sys_rst, 1);
    rd_plain(v); check("R7 por flags", v, 8'h02);
    rd_rmw(v);   check("R7 por enables", v, 8'h02);
    por_n = 1'b1;
    pulse_len(n);
    check("R7 release length", n, 16);
    check("R1 idle read strobe off", rdata, 8'h00);
  endtask

  task automatic t_views;
    logic [7:0] v;
    wr(8'hCF);
    rd_plain(v); check("R3 ignored bits keep flags", v, 8'h02);
    rd_rmw(v);   check("R2 rmw view 0xCF write", v, 8'h06);
    wr(8'h22);
    rd_rmw(v);   check("R2 rmw view cmp only", v, 8'h22);
    rd_plain(v); check("R1 plain view unchanged", v, 8'h02);
    wr(8'h26);
    rd_rmw(v);   check("R3 all enables", v, 8'h26);
  endtask

  task automatic t_sw;
    logic [7:0] v;
    wr(8'h26);
    expect_quiet("R4 write 0 to force", 8'h02);
    wr(8'h36);
    expect_reset("R4 software force", 8'h10);
    rd_rmw(v); check("R12 enables kept after sw", v, 8'h26);
  endtask

  task automatic t_cmp;
    @(negedge clk); cmp_n = 1'b0; @(negedge clk); cmp_n = 1'b1;
    expect_reset("R5 comparator", 8'h20);
    wr(8'h06);
    @(negedge clk); cmp_n = 1'b0; repeat (3) @(negedge clk); cmp_n = 1'b1;
    expect_quiet("R5 comparator disabled", 8'h20);
    wr(8'h26);
  endtask

  task automatic t_mcd;
    @(negedge clk); clk_miss = 1'b1; @(negedge clk); clk_miss = 1'b0;
    expect_reset("R6 missing clock", 8'h04);
    wr(8'h22);
    @(negedge clk); clk_miss = 1'b1; @(negedge clk); clk_miss = 1'b0;
    expect_quiet("R6 missing clock disabled", 8'h04);
    wr(8'h26);
  endtask

  task automatic t_vmon;
    logic [7:0] v;
    @(negedge clk); vmon_trip = 1'b1; @(negedge clk); vmon_trip = 1'b0;
    expect_reset("R8 supply trip", 8'h02);
    rd_rmw(v); check("R8 enables kept", v, 8'h26);
    wr(8'h24);
    @(negedge clk); vmon_trip = 1'b1; @(negedge clk); vmon_trip = 1'b0;
    expect_quiet("R8 supply trip disabled", 8'h02);
    wr(8'h26);
  endtask

  task automatic t_fixed;
    @(negedge clk); pin_rst = 1'b1; @(negedge clk); pin_rst = 1'b0;
    expect_reset("R9 pin", 8'h01);
    @(negedge clk); wdt_expire = 1'b1; @(negedge clk); wdt_expire = 1'b0;
    expect_reset("R9 watchdog", 8'h08);
    @(negedge clk); flash_err = 1'b1; @(negedge clk); flash_err = 1'b0;
    expect_reset("R9 flash error", 8'h40);
  endtask

  task automatic t_prio;
    @(negedge clk); pin_rst = 1'b1; wdt_expire = 1'b1;
    @(negedge clk); pin_rst = 1'b0; wdt_expire = 1'b0;
    expect_reset("R10 pin over watchdog", 8'h01);
    @(negedge clk); wdt_expire = 1'b1; clk_miss = 1'b1; flash_err = 1'b1;
    @(negedge clk); wdt_expire = 1'b0; clk_miss = 1'b0; flash_err = 1'b0;
    expect_reset("R10 watchdog over mcd", 8'h08);
    @(negedge clk); clk_miss = 1'b1; cmp_n = 1'b0;
    @(negedge clk); clk_miss = 1'b0; cmp_n = 1'b1;
    expect_reset("R10 mcd over comparator", 8'h04);
    @(negedge clk); cmp_n = 1'b0; flash_err = 1'b1;
    @(negedge clk); cmp_n = 1'b1; flash_err = 1'b0;
    expect_reset("R10 comparator over flash", 8'h20);
    @(negedge clk); flash_err = 1'b1; wr_en = 1'b1; wdata = 8'h36;
    @(negedge clk); flash_err = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    expect_reset("R10 flash over software", 8'h40);
    @(negedge clk); vmon_trip = 1'b1; pin_rst = 1'b1;
    @(negedge clk); vmon_trip = 1'b0; pin_rst = 1'b0;
    expect_reset("R10 supply over pin", 8'h02);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    int n;
    @(negedge clk); pin_rst = 1'b1; @(negedge clk); pin_rst = 1'b0;
    check("R12 pulse started", sys_rst, 1);
    wdt_expire = 1'b1; wr_en = 1'b1; wdata = 8'h10;
    @(posedge clk); @(negedge clk);
    wdt_expire = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    pulse_len(n);
    check("R12 pulse not extended", n + 1, 16);
    rd_plain(v); check("R12 flags kept pin", v, 8'h01);
    rd_rmw(v);   check("R12 enables kept", v, 8'h27);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    report();
  end

  initial begin
    t_por();
    t_views();
    t_sw();
    t_cmp();
    t_mcd();
    t_vmon();
    t_fixed();
    t_prio();
    t_busy();
    report();
  end
endmodule